// File: doc/BRIEF.md
# Flash Write-Status Read Word Generator

This block forms the word that a flash read returns while an embedded program or erase is running or while an erase is suspended. It watches the operation state (program running, erase running, erase suspended), a flag that says whether the current read address falls inside the suspended erase region, the data word latched for the running program, and the array word from the normal read path. On each read strobe it registers one 16-bit result.

During a status read, three bits carry progress information:
- Bit 7 is the polling bit. It is the inverted programmed bit while a program runs, 0 while an erase runs, and 1 on a suspended-region read.
- Bit 6 is a toggle that flips on every read while an operation is active.
- Bit 2 is a second toggle. It flips on erase reads and on suspended-region reads, which lets software tell an erasing region from a suspended one.

All other bits are zero during a status read. When no status applies, the array word passes through unchanged. The toggles count reads, not time.

Top module: `flash_status_word`

## Requirements
- R1: While a program is running, bit 7 of each read result is the inverse of bit 7 of the latched program data.
- R2: While an erase is running and not suspended, bit 7 of each read result is 0.
- R3: While a program or an erase is running, bit 6 starts at 0 on the first read after a launch and alternates on every following read.
- R4: During erase suspend, a read with the in-suspended-region flag set returns bit 7 = 1 and bit 6 = 1, while bit 2 alternates on each such read.
- R5: Bit 2 keeps its value across program-status reads and alternates on each erase-status read.
- R6: With no operation running, or during erase suspend with the flag clear, the result equals the array word exactly.
- R7: Both toggles change only on a read strobe; a launch pulse clears both to 0. Cycles with no strobe leave the toggle sequence where it was.
- R8: During any status read, every bit other than 7, 6 and 2 is 0.
- R9: The result register is 0 after reset. It takes a new value in the clock after a strobe and holds it otherwise.
- R10: A running program takes priority over suspend and erase status. A program started during suspend reports program status, even when the in-suspended-region flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_launch | input | 1 | One-cycle pulse when a program or erase is started |
| prog_busy | input | 1 | Embedded program running |
| erase_busy | input | 1 | Embedded erase running |
| erase_susp | input | 1 | Erase suspended |
| addr_in_susp | input | 1 | Read address lies in the suspended region |
| prog_data | input | 16 | Latched data of the running program |
| array_data | input | 16 | Word from the array read path |
| rd_strobe | input | 1 | One-cycle read request |
| rd_data | output | 16 | Registered read result |

## Verification
A toggle that is stuck or advances in the wrong mode shows up at bit 6 or bit 2 on the very next read. That read lands one clock after the strobe, and the alternation no longer matches the count of reads since the launch. A wrong mode decision shows up within one read. It appears either as polling bit 7 at the wrong polarity or as array bits leaking into a status word. The bench therefore reads several times in each mode. It leaves idle gaps between reads and relaunches in the middle of a suspend, so that every toggle history is visible at the port.

// File: rtl/fsw_pkg.sv
package fsw_pkg;

  typedef enum logic [1:0] {
    FSW_ARRAY    = 2'd0,
    FSW_PROG     = 2'd1,
    FSW_ERASE    = 2'd2,
    FSW_SUSP_HIT = 2'd3
  } fsw_mode_e;

  // Priority: program first, then suspended-region hit, then live erase.
  function automatic fsw_mode_e fsw_pick_mode(input logic prog, input logic erase,
                                              input logic susp, input logic hit);
    if (prog)              return FSW_PROG;
    else if (susp && hit)  return FSW_SUSP_HIT;
    else if (erase && !susp) return FSW_ERASE;
    else                   return FSW_ARRAY;
  endfunction

  function automatic logic fsw_adv_main(input fsw_mode_e m);
    return (m == FSW_PROG) || (m == FSW_ERASE);
  endfunction

  function automatic logic fsw_adv_aux(input fsw_mode_e m);
    return (m == FSW_ERASE) || (m == FSW_SUSP_HIT);
  endfunction

endpackage

// File: rtl/fsw_mode_decode.sv
module fsw_mode_decode
  import fsw_pkg::*;
(
  input  logic      prog_busy,
  input  logic      erase_busy,
  input  logic      erase_susp,
  input  logic      addr_in_susp,
  output fsw_mode_e mode,
  output logic      adv_main,
  output logic      adv_aux
);

  always_comb begin
    mode     = fsw_pick_mode(prog_busy, erase_busy, erase_susp, addr_in_susp);
    adv_main = fsw_adv_main(mode);
    adv_aux  = fsw_adv_aux(mode);
  end

endmodule

// File: rtl/fsw_toggle_bank.sv
module fsw_toggle_bank #(
  parameter int unsigned NUM_TOG = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               strobe,
  input  logic [NUM_TOG-1:0] adv,
  output logic [NUM_TOG-1:0] q
);

  for (genvar i = 0; i < NUM_TOG; i++) begin : g_tog
    logic step;
    assign step = strobe && adv[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[i] <= 1'b0;
      else if (clear) q[i] <= 1'b0;
      else if (step)  q[i] <= ~q[i];
    end

    assert_tog_flips_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && adv[i] && !clear) |=> (q[i] != $past(q[i])));

    assert_tog_idle_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe && !clear) |=> $stable(q[i]));

    assert_tog_clear_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (q[i] == 1'b0));
  end

endmodule

// File: rtl/fsw_word_mux.sv
module fsw_word_mux
  import fsw_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned POLL_BIT = 7,
  parameter int unsigned TOG_BIT  = 6,
  parameter int unsigned SUSP_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  fsw_mode_e         mode,
  input  logic              tog_main,
  input  logic              tog_aux,
  input  logic [DATA_W-1:0] prog_data,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [DATA_W-1:0] STATUS_MASK =
    (DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOG_BIT) | (DATA_W'(1) << SUSP_BIT);

  function automatic logic [DATA_W-1:0] status_word(input logic poll, input logic t6,
                                                    input logic t2);
    logic [DATA_W-1:0] w;
    w           = '0;
    w[POLL_BIT] = poll;
    w[TOG_BIT]  = t6;
    w[SUSP_BIT] = t2;
    return w;
  endfunction

  logic [DATA_W-1:0] next_word;
  logic              status_read;

  always_comb begin
    status_read = (mode != FSW_ARRAY);
    unique case (mode)
      FSW_PROG:     next_word = status_word(~prog_data[POLL_BIT], tog_main, tog_aux);
      FSW_ERASE:    next_word = status_word(1'b0, tog_main, tog_aux);
      FSW_SUSP_HIT: next_word = status_word(1'b1, 1'b1, tog_aux);
      default:      next_word = array_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (strobe) rd_data <= next_word;
  end

  assert_erase_poll_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && mode == FSW_ERASE) |=> (rd_data[POLL_BIT] == 1'b0));

  assert_susp_fixed_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && mode == FSW_SUSP_HIT) |=> (rd_data[POLL_BIT] && rd_data[TOG_BIT]));

  assert_array_pass_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && mode == FSW_ARRAY) |=> (rd_data == $past(array_data)));

  assert_unused_zero_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && status_read) |=> ((rd_data & ~STATUS_MASK) == '0));

  assert_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(rd_data));

endmodule

// File: rtl/flash_status_word.sv
module flash_status_word
  import fsw_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned POLL_BIT = 7,
  parameter int unsigned TOG_BIT  = 6,
  parameter int unsigned SUSP_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_launch,
  input  logic              prog_busy,
  input  logic              erase_busy,
  input  logic              erase_susp,
  input  logic              addr_in_susp,
  input  logic [DATA_W-1:0] prog_data,
  input  logic [DATA_W-1:0] array_data,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rd_data
);

  localparam int unsigned NUM_TOG = 2;
  localparam int unsigned IDX_MAIN = 0;
  localparam int unsigned IDX_AUX  = 1;

  fsw_mode_e          cur_mode;
  logic               adv_main;
  logic               adv_aux;
  logic [NUM_TOG-1:0] tog_adv;
  logic [NUM_TOG-1:0] tog_q;

  fsw_mode_decode u_dec (
    .prog_busy   (prog_busy),
    .erase_busy  (erase_busy),
    .erase_susp  (erase_susp),
    .addr_in_susp(addr_in_susp),
    .mode        (cur_mode),
    .adv_main    (adv_main),
    .adv_aux     (adv_aux)
  );

  assign tog_adv[IDX_MAIN] = adv_main;
  assign tog_adv[IDX_AUX]  = adv_aux;

  fsw_toggle_bank #(.NUM_TOG(NUM_TOG)) u_tog (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (op_launch),
    .strobe(rd_strobe),
    .adv   (tog_adv),
    .q     (tog_q)
  );

  fsw_word_mux #(
    .DATA_W  (DATA_W),
    .POLL_BIT(POLL_BIT),
    .TOG_BIT (TOG_BIT),
    .SUSP_BIT(SUSP_BIT)
  ) u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (rd_strobe),
    .mode      (cur_mode),
    .tog_main  (tog_q[IDX_MAIN]),
    .tog_aux   (tog_q[IDX_AUX]),
    .prog_data (prog_data),
    .array_data(array_data),
    .rd_data   (rd_data)
  );

  // Raw-port view: program status wins regardless of suspend/erase inputs.
  assert_prog_poll_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && prog_busy) |=> (rd_data[POLL_BIT] == ~$past(prog_data[POLL_BIT])));

  assert_prog_priority_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && prog_busy && erase_susp && addr_in_susp)
      |=> (rd_data[TOG_BIT] == $past(tog_q[IDX_MAIN])));

  assert_aux_hold_prog_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && prog_busy && !op_launch) |=> $stable(tog_q[IDX_AUX]));

endmodule

// File: tb/sim_flash_status_word.sv
`timescale 1ns/1ps
module sim_flash_status_word;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_launch = 1'b0;
  logic        prog_busy = 1'b0;
  logic        erase_busy = 1'b0;
  logic        erase_susp = 1'b0;
  logic        addr_in_susp = 1'b0;
  logic [15:0] prog_data = '0;
  logic [15:0] array_data = '0;
  logic        rd_strobe = 1'b0;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        m6 = 1'b0;
  logic        m2 = 1'b0;
  logic        cap = 1'b0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  flash_status_word u0 (
    .clk(clk), .rst_n(rst_n), .op_launch(op_launch), .prog_busy(prog_busy),
    .erase_busy(erase_busy), .erase_susp(erase_susp), .addr_in_susp(addr_in_susp),
    .prog_data(prog_data), .array_data(array_data), .rd_strobe(rd_strobe),
    .rd_data(rd_data)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Bench model of one read: expected word from the requirements.
  task automatic rd(string tag);
    logic [15:0] e;
    e = '0;
    if (prog_busy) begin                      // R1 R10
      e[7] = ~prog_data[7]; e[6] = m6; e[2] = m2;
      m6 = ~m6;                               // R3, bit 2 held (R5)
    end else if (erase_susp && addr_in_susp) begin  // R4
      e[7] = 1'b1; e[6] = 1'b1; e[2] = m2;
      m2 = ~m2;
    end else if (erase_busy && !erase_susp) begin   // R2
      e[7] = 1'b0; e[6] = m6; e[2] = m2;
      m6 = ~m6; m2 = ~m2;
    end else begin
      e = array_data;                         // R6
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
  endtask

  task automatic launch();
    @(negedge clk) op_launch = 1'b1;
    @(negedge clk) op_launch = 1'b0;
    m6 = 1'b0; m2 = 1'b0;                     // R7
  endtask

  // Scoreboard monitor
  always @(posedge clk) cap <= rd_strobe;
  always @(negedge clk) begin
    if (cap && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, rd_data, e);
    end
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset value", rd_data, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    // Program with data bit 7 = 1 -> polling reads 0
    prog_data = 16'h0080;
    launch(); prog_busy = 1'b1;
    for (int i = 0; i < 4; i++) rd("R1 R3 R5 program status");
    repeat (2) @(negedge clk);
    // Idle gap: result holds, toggle sequence paused
    repeat (5) @(negedge clk);
    check("R9 hold without strobe", rd_data, 16'h0040);
    rd("R7 toggle after idle gap");
    prog_data = 16'hFF7F;
    rd("R1 R8 inverted bit7 with busy data");

    // Done: array pass-through
    prog_busy = 1'b0; array_data = 16'hA5C3;
    rd("R6 idle array");
    array_data = 16'hFFFF;
    rd("R6 idle array all ones");

    // Erase
    launch(); erase_busy = 1'b1;
    for (int i = 0; i < 3; i++) rd("R2 R3 R5 erase status");

    // Suspend, read suspended region
    erase_susp = 1'b1; addr_in_susp = 1'b1;
    for (int i = 0; i < 3; i++) rd("R4 R8 suspended region");
    // Suspend, read elsewhere
    addr_in_susp = 1'b0; array_data = 16'h1234;
    rd("R6 suspend outside region");

    // Program during suspend, address flag set: program wins
    addr_in_susp = 1'b1; prog_data = 16'h0000;
    launch(); prog_busy = 1'b1;
    for (int i = 0; i < 3; i++) rd("R10 program over suspend");
    prog_busy = 1'b0;
    for (int i = 0; i < 2; i++) rd("R4 suspended after program");

    // Resume erase
    erase_susp = 1'b0; addr_in_susp = 1'b0;
    for (int i = 0; i < 2; i++) rd("R3 R5 resumed erase");

    // Launch pulse alone clears toggles
    launch();
    for (int i = 0; i < 2; i++) rd("R7 cleared by launch");

    erase_busy = 1'b0; array_data = 16'h5A5A;
    rd("R6 after erase done");

    repeat (4) @(negedge clk);
    check("R9 final hold", rd_data, 16'h5A5A);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule